// File: doc/BRIEF.md
# Block Memory Copy Engine

This engine moves a run of bytes from one 16-bit address to another through a single memory port. Software-visible state is passed in at start as a source pointer, a destination pointer, a 16-bit byte count and the current flag byte. The engine hands back the updated versions of all four when it finishes. Four forms are selected by a 2-bit operation code: a single-byte step or an auto-repeating run, each moving either upward or downward through memory.

Repeating runs are bounded by a cycle budget and charge a fixed cost per byte. If the budget runs out before the count reaches zero, the engine stops, marks the subtract flag and raises a request for the caller to move its program counter back by two. This lets the same operation be reissued later and carry on where it stopped. A run that completes refunds part of the last byte's cost. Each memory access is a request/acknowledge transaction. The read of a byte always completes before that byte's write is issued.

Top module: `blkcpy_engine`

## Requirements
- R1: After reset the engine is idle: busy_o, done_o, mem_req_o and rewind_o are low, and cycles_o and flags_o are zero.
- R2: Each byte is a read at the source pointer followed by a write of the data just read at the destination pointer. The write request is not raised until the read has been acknowledged.
- R3: After each byte both pointers move together, by +1 when op_i[0]=0 (ascending) or by -1 when op_i[0]=1 (descending). They wrap modulo 65536.
- R4: The count drops by one per byte, modulo 65536. A starting count of zero therefore wraps to 0xFFFF after the first byte.
- R5: A single-step form (op_i[1]=0) copies exactly one byte. It clears flag bits 1 (subtract), 4 (half-carry) and 2 (parity/overflow), then sets bit 2 if the resulting count is nonzero. All other flag bits pass through unchanged. cycles_o is 0 and rewind_o is low.
- R6: A repeating form (op_i[1]=1) copies at least one byte and charges 21 cycles per byte. After each byte it goes on only while the count is nonzero and the cycles charged so far are below budget_i.
- R7: When a repeat ends with the count at zero, cycles_o equals 21 times the bytes copied minus 5. Flag bits 1, 2 and 4 end cleared, and rewind_o stays low.
- R8: When a repeat stops with the count nonzero, flag bit 1 is set, bits 2 and 4 are cleared, cycles_o equals 21 times the bytes copied, and rewind_o is high.
- R9: start_i is ignored while busy_o is high. It does not change the operation in progress or its results.
- R10: done_o pulses for exactly one cycle after the last write is acknowledged, with busy_o low from that cycle on. The result outputs then hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation when idle |
| op_i | input | 2 | bit 0: descending; bit 1: repeat |
| src_i | input | 16 | Starting source pointer |
| dst_i | input | 16 | Starting destination pointer |
| cnt_i | input | 16 | Starting byte count |
| flags_i | input | 8 | Incoming flag byte |
| budget_i | input | 24 | Cycle budget for repeating forms |
| mem_req_o | output | 1 | Memory request, held until acknowledged |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| src_o | output | 16 | Updated source pointer |
| dst_o | output | 16 | Updated destination pointer |
| cnt_o | output | 16 | Updated count |
| flags_o | output | 8 | Updated flag byte |
| cycles_o | output | 24 | Cycles charged |
| rewind_o | output | 1 | Request to move the program counter back by 2 |

## Verification
Some properties are checked on every cycle:
- the write that follows a read acknowledge carries the data just read;
- both pointers move by the same amount on each byte;
- the count falls by one per byte;
- done_o never lasts two cycles;
- the operation code stays stable while busy;
- a rewind always comes with the subtract flag set and the budget spent.

The remaining behaviour can only be shown by the bench's scenarios against its reference model:
- the exact order and addresses of the transactions, including overlapping copies;
- when a run stops relative to the budget;
- the 5-cycle refund;
- wrap of a zero count and of pointers through address zero;
- a start pulse that must be ignored mid-run.

// File: rtl/blkcpy_pkg.sv
package blkcpy_pkg;
  localparam int OP_DESC_BIT = 0;
  localparam int OP_REP_BIT  = 1;

  localparam logic [7:0] FLG_SUB  = 8'h02;
  localparam logic [7:0] FLG_PV   = 8'h04;
  localparam logic [7:0] FLG_HALF = 8'h10;
  localparam logic [7:0] FLG_CLR  = FLG_SUB | FLG_PV | FLG_HALF;

  localparam int unsigned BYTE_COST  = 21;
  localparam int unsigned END_REFUND = 5;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RD   = 2'd1,
    SEQ_WR   = 2'd2
  } seq_state_e;
endpackage

// File: rtl/blkcpy_mem_seq.sv
module blkcpy_mem_seq
  import blkcpy_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          more_i,
  input  logic [AW-1:0] rd_addr_i,
  input  logic [AW-1:0] wr_addr_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_ack_i,
  output logic          byte_done_o
);
  seq_state_e    state_q, state_d;
  logic [DW-1:0] data_q;
  logic          held_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE: if (go_i) state_d = SEQ_RD;
      SEQ_RD:   if (mem_ack_i) state_d = SEQ_WR;
      SEQ_WR:   if (mem_ack_i) state_d = more_i ? SEQ_RD : SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      data_q  <= '0;
      held_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == SEQ_RD && mem_ack_i) begin
        data_q <= mem_rdata_i;
        held_q <= 1'b1;
      end else if (state_q == SEQ_WR && mem_ack_i) begin
        held_q <= 1'b0;
      end
    end
  end

  assign mem_req_o   = (state_q == SEQ_RD) || (state_q == SEQ_WR);
  assign mem_we_o    = (state_q == SEQ_WR);
  assign mem_addr_o  = (state_q == SEQ_WR) ? wr_addr_i : rd_addr_i;
  assign mem_wdata_o = data_q;
  assign byte_done_o = (state_q == SEQ_WR) && mem_ack_i;

  // R2
  wr_after_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> held_q);
  // R2
  wr_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_ack_i) |=> (mem_we_o && mem_wdata_o == $past(mem_rdata_i)));
endmodule

// File: rtl/blkcpy_ptr_unit.sv
module blkcpy_ptr_unit #(
  parameter int AW = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic             desc_i,
  input  logic [AW-1:0]    src_i,
  input  logic [AW-1:0]    dst_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [AW-1:0]    src_o,
  output logic [AW-1:0]    dst_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [AW-1:0]    src_q, dst_q;
  logic [CNT_W-1:0] cnt_q;
  logic [AW-1:0]    delta;

  // two's-complement step: +1 or all-ones (-1), wraps modulo 2**AW
  assign delta = desc_i ? {AW{1'b1}} : AW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      src_q <= src_i;
      dst_q <= dst_i;
      cnt_q <= cnt_i;
    end else if (step_i) begin
      src_q <= src_q + delta;
      dst_q <= dst_q + delta;
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign src_o = src_q;
  assign dst_o = dst_q;
  assign cnt_o = cnt_q;

  // R3
  ptr_lockstep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (AW'(src_q - $past(src_q)) == AW'(dst_q - $past(dst_q))));
  // R4
  cnt_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> (CNT_W'($past(cnt_q) - cnt_q) == CNT_W'(1)));
endmodule

// File: rtl/blkcpy_acct.sv
module blkcpy_acct
  import blkcpy_pkg::*;
#(
  parameter int CYC_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [7:0]       flags_i,
  input  logic             rep_i,
  input  logic             step_i,
  input  logic             last_i,
  input  logic             cnt_zero_i,
  output logic [CYC_W-1:0] used_next_o,
  output logic [CYC_W-1:0] cycles_o,
  output logic [7:0]       flags_o,
  output logic             rewind_o
);
  logic [CYC_W-1:0] cyc_q;
  logic [7:0]       flg_q;
  logic             rew_q;
  logic [7:0]       flg_base;

  assign used_next_o = cyc_q + CYC_W'(BYTE_COST);
  assign flg_base    = flg_q & ~FLG_CLR;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
      flg_q <= '0;
      rew_q <= 1'b0;
    end else if (load_i) begin
      cyc_q <= '0;
      flg_q <= flags_i;
      rew_q <= 1'b0;
    end else if (step_i) begin
      if (rep_i) begin
        cyc_q <= (last_i && cnt_zero_i) ? used_next_o - CYC_W'(END_REFUND) : used_next_o;
      end
      if (last_i) begin
        if (!rep_i) begin
          flg_q <= flg_base | (cnt_zero_i ? 8'h00 : FLG_PV);
          rew_q <= 1'b0;
        end else begin
          flg_q <= flg_base | (cnt_zero_i ? 8'h00 : FLG_SUB);
          rew_q <= !cnt_zero_i;
        end
      end
    end
  end

  assign cycles_o = cyc_q;
  assign flags_o  = flg_q;
  assign rewind_o = rew_q;

  // R8
  rewind_sub_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rewind_o |-> ((flags_o & FLG_CLR) == FLG_SUB));
  // R5
  single_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rep_i && !load_i) |=> (cycles_o == '0));
endmodule

// File: rtl/blkcpy_engine.sv
module blkcpy_engine
  import blkcpy_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int CNT_W = 16,
  parameter int CYC_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic [AW-1:0]    src_i,
  input  logic [AW-1:0]    dst_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [7:0]       flags_i,
  input  logic [CYC_W-1:0] budget_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_wdata_o,
  input  logic [DW-1:0]    mem_rdata_i,
  input  logic             mem_ack_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [AW-1:0]    src_o,
  output logic [AW-1:0]    dst_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [7:0]       flags_o,
  output logic [CYC_W-1:0] cycles_o,
  output logic             rewind_o
);
  logic             busy_q, done_q;
  logic [1:0]       op_q;
  logic [CYC_W-1:0] budget_q;
  logic             accept, step, last, more, cnt_zero;
  logic [CNT_W-1:0] cnt_next;
  logic [CYC_W-1:0] used_next;

  assign accept   = start_i && !busy_q;
  assign cnt_next = cnt_o - CNT_W'(1);
  assign cnt_zero = (cnt_next == '0);
  assign more     = op_q[OP_REP_BIT] && !cnt_zero && (used_next < budget_q);
  assign last     = step && !more;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      op_q     <= '0;
      budget_q <= '0;
    end else begin
      done_q <= last;
      if (accept) begin
        busy_q   <= 1'b1;
        op_q     <= op_i;
        budget_q <= budget_i;
      end else if (last) begin
        busy_q <= 1'b0;
      end
    end
  end

  blkcpy_mem_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_i        (accept),
    .more_i      (more),
    .rd_addr_i   (src_o),
    .wr_addr_i   (dst_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_ack_i   (mem_ack_i),
    .byte_done_o (step)
  );

  blkcpy_ptr_unit #(.AW(AW), .CNT_W(CNT_W)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .step_i (step),
    .desc_i (op_q[OP_DESC_BIT]),
    .src_i  (src_i),
    .dst_i  (dst_i),
    .cnt_i  (cnt_i),
    .src_o  (src_o),
    .dst_o  (dst_o),
    .cnt_o  (cnt_o)
  );

  blkcpy_acct #(.CYC_W(CYC_W)) u_acct (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (accept),
    .flags_i     (flags_i),
    .rep_i       (op_q[OP_REP_BIT]),
    .step_i      (step),
    .last_i      (last),
    .cnt_zero_i  (cnt_zero),
    .used_next_o (used_next),
    .cycles_o    (cycles_o),
    .flags_o     (flags_o),
    .rewind_o    (rewind_o)
  );

  assign busy_o = busy_q;
  assign done_o = done_q;

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R6
  rewind_budget_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && rewind_o) |-> (cycles_o >= budget_q));
  // R9
  op_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(op_q));
  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
endmodule

// File: tb/blkcpy_engine_bench.sv
module blkcpy_engine_bench;
  localparam int CW = 24;
  localparam int WD_LIMIT = 150000;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    op_i = '0;
  logic [15:0]   src_i = '0, dst_i = '0, cnt_i = '0;
  logic [7:0]    flags_i = '0;
  logic [CW-1:0] budget_i = '0;
  logic          mem_req_o, mem_we_o;
  logic [15:0]   mem_addr_o;
  logic [7:0]    mem_wdata_o;
  logic [7:0]    mem_rdata_i = '0;
  logic          mem_ack_i = 1'b0;
  logic          busy_o, done_o, rewind_o;
  logic [15:0]   src_o, dst_o, cnt_o;
  logic [7:0]    flags_o;
  logic [CW-1:0] cycles_o;

  always #10 clk_i = ~clk_i;

  blkcpy_engine u_blkcpy_engine (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .src_i(src_i), .dst_i(dst_i), .cnt_i(cnt_i), .flags_i(flags_i),
    .budget_i(budget_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i), .busy_o(busy_o),
    .done_o(done_o), .src_o(src_o), .dst_o(dst_o), .cnt_o(cnt_o),
    .flags_o(flags_o), .cycles_o(cycles_o), .rewind_o(rewind_o)
  );

  int total = 0, bad = 0, cyc = 0, ntx = 0, wait_cnt = 0;
  logic [7:0]  dut_mem [int];
  logic [7:0]  ref_mem [int];
  logic [15:0] q_addr [$];
  bit          q_we [$];
  logic [7:0]  q_data [$];

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [7:0] seed_val(int a);
    return 8'(a ^ (a >> 8) ^ 8'h5a);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // memory responder with varying latency; checks each transaction against the model (R2)
  initial begin
    forever begin
      @(negedge clk_i);
      if (mem_ack_i) begin
        mem_ack_i = 1'b0;
      end else if (mem_req_o) begin
        if (wait_cnt == 0) begin
          if (q_addr.size() == 0) begin
            check(0, "R2 unexpected access", mem_addr_o, 0);
          end else begin
            logic [15:0] ea;
            bit ew;
            logic [7:0] ed;
            ea = q_addr.pop_front();
            ew = q_we.pop_front();
            ed = q_data.pop_front();
            check(mem_addr_o == ea, "R2 addr", mem_addr_o, ea);
            check(mem_we_o == ew, "R2 order", mem_we_o, ew);
            if (ew) check(mem_wdata_o == ed, "R2 data", mem_wdata_o, ed);
          end
          if (mem_we_o) dut_mem[int'(mem_addr_o)] = mem_wdata_o;
          else mem_rdata_i = dut_mem.exists(int'(mem_addr_o)) ?
                             dut_mem[int'(mem_addr_o)] : seed_val(int'(mem_addr_o));
          mem_ack_i = 1'b1;
          ntx++;
          wait_cnt = ntx % 3;
        end else begin
          wait_cnt--;
        end
      end
    end
  end

  task automatic run_op(input logic [1:0] op, input logic [15:0] s, input logic [15:0] d,
                        input logic [15:0] c, input logic [7:0] f, input int budget,
                        input bit poke, input string tag);
    bit rep = op[1];
    logic [15:0] ms = s, md = d, mc = c, step;
    int used = 0, bytes = 0;
    logic [7:0] v, ef;
    int ecyc;
    bit erew;
    step = op[0] ? 16'hffff : 16'h0001;
    do begin
      v = ref_mem.exists(int'(ms)) ? ref_mem[int'(ms)] : seed_val(int'(ms));
      q_addr.push_back(ms); q_we.push_back(1'b0); q_data.push_back(8'h00);
      q_addr.push_back(md); q_we.push_back(1'b1); q_data.push_back(v);
      ref_mem[int'(md)] = v;
      ms = ms + step; md = md + step; mc = mc - 16'd1;
      used += 21; bytes++;
    end while (rep && mc != 0 && used < budget);
    if (!rep) begin
      ef = (f & ~8'h16) | ((mc != 0) ? 8'h04 : 8'h00);
      ecyc = 0; erew = 0;
    end else begin
      ef = (f & ~8'h16) | ((mc != 0) ? 8'h02 : 8'h00);
      ecyc = used - ((mc == 0) ? 5 : 0);
      erew = (mc != 0);
    end

    @(negedge clk_i);
    op_i = op; src_i = s; dst_i = d; cnt_i = c; flags_i = f; budget_i = CW'(budget);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    if (poke) begin
      // R9: second start while busy must be ignored
      @(negedge clk_i);
      op_i = ~op; src_i = 16'h1234; dst_i = 16'h4321; cnt_i = 16'h0003;
      flags_i = 8'h00; budget_i = '0; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
      check(busy_o == 1'b1, "R9 still busy", busy_o, 1);
    end
    while (!done_o) begin
      @(negedge clk_i);
      if (cyc > WD_LIMIT) begin
        check(0, "watchdog", cyc, WD_LIMIT);
        finish_run();
      end
    end
    check(src_o == ms, {tag, " R3 src"}, src_o, ms);
    check(dst_o == md, {tag, " R3 dst"}, dst_o, md);
    check(cnt_o == mc, {tag, " R4 cnt"}, cnt_o, mc);
    check(flags_o == ef, {tag, rep ? " R7/R8 flags" : " R5 flags"}, flags_o, ef);
    check(cycles_o == CW'(ecyc), {tag, " R6 cycles"}, cycles_o, ecyc);
    check(rewind_o == erew, {tag, " R8 rewind"}, rewind_o, erew);
    check(busy_o == 1'b0, {tag, " R10 busy"}, busy_o, 0);
    check(q_addr.size() == 0, {tag, " R2 pending"}, q_addr.size(), 0);
    @(negedge clk_i);
    check(done_o == 1'b0, {tag, " R10 pulse"}, done_o, 0);
    check(cnt_o == mc, {tag, " R10 hold"}, cnt_o, mc);
    if (poke) check(src_o == ms, {tag, " R9 result kept"}, src_o, ms);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1
    check(busy_o == 0 && done_o == 0, "R1 idle", {busy_o, done_o}, 0);
    check(mem_req_o == 0 && rewind_o == 0, "R1 quiet", {mem_req_o, rewind_o}, 0);
    check(cycles_o == 0 && flags_o == 0, "R1 zero", flags_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    run_op(2'b00, 16'h0100, 16'h0200, 16'd5,    8'hff, 0,    0, "single asc R5");
    run_op(2'b01, 16'h0300, 16'h0000, 16'd1,    8'h16, 0,    0, "single desc R3");
    run_op(2'b00, 16'h0500, 16'h0600, 16'h0000, 8'h01, 0,    0, "single zero R4");
    run_op(2'b10, 16'h1000, 16'h2000, 16'd8,    8'hff, 1000, 1, "rep asc R7 R9");
    run_op(2'b11, 16'h0002, 16'h0004, 16'd6,    8'h00, 1000, 0, "rep desc wrap R3");
    run_op(2'b10, 16'h3000, 16'h3100, 16'd20,   8'h00, 63,   0, "rep budget R8");
    run_op(2'b10, 16'h4000, 16'h5000, 16'h0000, 8'h80, 100,  0, "rep zero R4");
    run_op(2'b10, 16'h6000, 16'h6001, 16'd4,    8'h00, 1000, 0, "rep overlap R2");
    run_op(2'b10, 16'h7000, 16'h7100, 16'd10,   8'h10, 0,    0, "rep nobudget R6");
    run_op(2'b10, 16'hfffe, 16'h8000, 16'd1,    8'h04, 500,  0, "rep one R7");
    run_op(2'b11, 16'h9000, 16'hffff, 16'd3,    8'h02, 1000, 0, "rep desc R7");

    finish_run();
  end
endmodule